// File: doc/BRIEF.md
# Shared-Counter Match Timer Bank

This block holds eight auxiliary timer channels, indexed 0 to 7 on the bus and known to software as channels 4 to 11. Each channel owns a 32-bit match value, a 32-bit up-counter and a control word. The control word picks which of four rate strobes advances the counter. It also says whether the channel compares against its own counter or against a group leader's counter, whether a match clears the counter, and whether matching re-arms after an event. Two channels can also request a snapshot of their neighbour's counter.

Prescaling happens outside the block. The block sees four one-cycle strobes, one per rate. A match sets one status bit if that channel is enabled, and a single interrupt line stays high while any status bit is set. Software clears status bits by writing ones. All access uses a 32-bit word bus: a write strobe, a read strobe and a byte address, with read data returned combinationally.

Top module: `tmrbank`

## Requirements
- R1: After reset, every counter, match value, control word, the enable mask, the status bits and the snapshot read as zero, and `irq_o` is low.
- R2: Control bits [2:0] pick the rate: code c in 1..4 advances the counter by one on each pulse of `tick_i[c-1]`. Bit 0 is the 32.768 kHz strobe, bit 1 is 1 kHz, bit 2 is 1 Hz and bit 3 is 1 MHz. Codes 0, 5, 6 and 7 leave the counter holding its value, and a read returns that held value.
- R3: Control words of indices 0..3 keep bits [7:0] and read the upper bits as zero. Control words of indices 4..7 keep bits [9:0]. On indices 4..7, control bit 8 stops the counter whatever the rate code is.
- R4: With control bit 7 clear, indices 1..3 compare against counter 0, index 5 against counter 4 and index 7 against counter 6. A follower's own counter does not advance. Indices 0, 4 and 6 always use their own counter. With bit 7 set, a channel compares against its own counter.
- R5: A bus write to a counter loads the written value at the next edge, and this load wins over a same-cycle increment. Channels that follow a shared counter compare against the loaded value from then on.
- R6: An event occurs in the cycle where the compared counter advances to equal the channel's match value. If the channel's enable bit is set, status bit (4 + index) is set at that edge and `irq_o` is high from the following cycle. A disabled channel's event sets no status bit.
- R7: Writing a match value arms the channel. With control bit 6 clear, an event disarms it, so later equalities raise nothing until the match value is written again. With bit 6 set, every equality raises an event.
- R8: With control bit 3 set, an event clears the channel's own counter to zero in place of the increment.
- R9: Writing ones to status bits [11:4] clears those bits. `irq_o` stays high while any status bit remains set and falls once none are set.
- R10: Reading counter 5 (or 7) while that channel's control bit 9 is set copies the current value of counter 4 (or 6) into the snapshot register. A read with bit 9 clear leaves the snapshot unchanged.
- R11: Loading a counter with a value equal to a match value raises no event.

Register addresses: match value n at 0x80 + 4n, counter n at 0x40 + 4n, control n at 0xC0 + 4n, snapshot at 0x20, status at 0x28 and enable mask at 0x2C. In the status and enable registers, bits [11:4] map to indices 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 4 | One-cycle rate strobes: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the snapshot side effect) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined event interrupt |

## Verification
The assertions assume that each rate strobe is a single-cycle pulse, and that an event can only follow a cycle in which some strobe is high. They also assume that the one-shot check applies only in cycles without a bus write, because a match or control write may re-arm the channel or change its mode. The stimulus issues at most one bus operation per cycle and draws each strobe bit independently. Match and counter values are kept below 64, so equalities occur often and snapshot reads land on both neighbour pairs.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;
    localparam int NCH    = 8;
    localparam int DW     = 32;
    localparam int CW     = 10;
    localparam int CW_LO  = 8;
    localparam int NRATE  = 4;
    localparam int ADDR_W = 8;
    localparam int EVT_LSB = 4;

    localparam logic [ADDR_W-1:0] A_MATCH = 8'h80;
    localparam logic [ADDR_W-1:0] A_CNT   = 8'h40;
    localparam logic [ADDR_W-1:0] A_CTL   = 8'hC0;
    localparam logic [ADDR_W-1:0] A_SNAP  = 8'h20;
    localparam logic [ADDR_W-1:0] A_STS   = 8'h28;
    localparam logic [ADDR_W-1:0] A_EN    = 8'h2C;

    // control bit positions
    localparam int CB_RST  = 3;
    localparam int CB_PER  = 6;
    localparam int CB_OWN  = 7;
    localparam int CB_EXT  = 8;
    localparam int CB_SNAP = 9;

    // group leader whose counter a follower compares against
    function automatic int base_of(input int n);
        if (n < NCH / 2) return 0;
        return n - (n % 2);
    endfunction

    typedef struct {
        logic [DW-1:0]  cnt [NCH];
        logic [DW-1:0]  mat [NCH];
        logic [CW-1:0]  ctl [NCH];
        logic [NCH-1:0] armed;
        logic [NCH-1:0] en;
        logic [NCH-1:0] sts;
        logic [DW-1:0]  snap;
    } st_t;
endpackage

// File: rtl/tmrbank_tick_sel.sv
module tmrbank_tick_sel #(
    parameter int NRATE   = 4,
    parameter bit IS_BASE = 1'b0,
    parameter bit HAS_EXT = 1'b0
) (
    input  logic [2:0]       code_i,
    input  logic             ext_i,
    input  logic             own_i,
    input  logic [NRATE-1:0] tick_i,
    output logic             adv_o
);
    logic sel;
    logic run;

    always_comb begin
        sel = 1'b0;
        for (int r = 0; r < NRATE; r++) begin
            if (code_i == 3'(r + 1)) sel = tick_i[r];
        end
        run = IS_BASE || own_i;
        if (HAS_EXT && ext_i) run = 1'b0;
        adv_o = sel && run;
    end
endmodule

// File: rtl/tmrbank_cmp.sv
module tmrbank_cmp #(
    parameter int DW = 32
) (
    input  logic          armed_i,
    input  logic          adv_i,
    input  logic [DW-1:0] cnt_i,
    input  logic [DW-1:0] match_i,
    output logic          hit_o
);
    logic [DW-1:0] nxt;

    assign nxt   = cnt_i + DW'(1);
    assign hit_o = armed_i && adv_i && (nxt == match_i);
endmodule

// File: rtl/tmrbank.sv
module tmrbank
    import tmrbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRATE-1:0]  tick_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o
);
    st_t st_q, st_d;

    logic [NCH-1:0] adv_w;
    logic [NCH-1:0] hit_w;
    logic [NCH-1:0] per_w;

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            localparam int BASE = base_of(n);
            logic          own;
            logic          cmp_adv;
            logic [DW-1:0] cmp_cnt;

            assign own = st_q.ctl[n][CB_OWN];

            tmrbank_tick_sel #(
                .NRATE  (NRATE),
                .IS_BASE(BASE == n),
                .HAS_EXT(n >= NCH / 2)
            ) u_tick (
                .code_i(st_q.ctl[n][2:0]),
                .ext_i (st_q.ctl[n][CB_EXT]),
                .own_i (own),
                .tick_i(tick_i),
                .adv_o (adv_w[n])
            );

            assign cmp_cnt = own ? st_q.cnt[n] : st_q.cnt[BASE];
            assign cmp_adv = own ? adv_w[n]    : adv_w[BASE];

            tmrbank_cmp #(.DW(DW)) u_cmp (
                .armed_i(st_q.armed[n]),
                .adv_i  (cmp_adv),
                .cnt_i  (cmp_cnt),
                .match_i(st_q.mat[n]),
                .hit_o  (hit_w[n])
            );

            assign per_w[n] = st_q.ctl[n][CB_PER];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NCH; n++) begin
            logic [ADDR_W-1:0] a_cnt, a_mat, a_ctl;
            a_cnt = A_CNT   + ADDR_W'(n * 4);
            a_mat = A_MATCH + ADDR_W'(n * 4);
            a_ctl = A_CTL   + ADDR_W'(n * 4);

            // counter: bus load > clear on match > increment
            if (adv_w[n]) st_d.cnt[n] = st_q.cnt[n] + DW'(1);
            if (hit_w[n] && st_q.ctl[n][CB_RST]) st_d.cnt[n] = '0;
            if (bus_wr && bus_addr == a_cnt) st_d.cnt[n] = bus_wdata;

            if (hit_w[n] && !st_q.ctl[n][CB_PER]) st_d.armed[n] = 1'b0;
            if (bus_wr && bus_addr == a_mat) begin
                st_d.mat[n]   = bus_wdata;
                st_d.armed[n] = 1'b1;
            end

            if (bus_wr && bus_addr == a_ctl) begin
                if (n < NCH / 2) st_d.ctl[n] = CW'(bus_wdata[CW_LO-1:0]);
                else             st_d.ctl[n] = bus_wdata[CW-1:0];
            end

            if (bus_rd && bus_addr == a_cnt && n >= NCH / 2 && (n % 2) == 1
                && st_q.ctl[n][CB_SNAP])
                st_d.snap = st_q.cnt[base_of(n)];
        end

        if (bus_wr && bus_addr == A_EN) st_d.en = bus_wdata[EVT_LSB +: NCH];
        if (bus_wr && bus_addr == A_STS)
            st_d.sts = st_q.sts & ~bus_wdata[EVT_LSB +: NCH];
        st_d.sts = st_d.sts | (hit_w & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCH; n++) begin
                st_q.cnt[n] <= '0;
                st_q.mat[n] <= '0;
                st_q.ctl[n] <= '0;
            end
            st_q.armed <= '0;
            st_q.en    <= '0;
            st_q.sts   <= '0;
            st_q.snap  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == A_CNT   + ADDR_W'(n * 4)) bus_rdata = st_q.cnt[n];
            if (bus_addr == A_MATCH + ADDR_W'(n * 4)) bus_rdata = st_q.mat[n];
            if (bus_addr == A_CTL   + ADDR_W'(n * 4)) bus_rdata = DW'(st_q.ctl[n]);
        end
        if (bus_addr == A_SNAP) bus_rdata = st_q.snap;
        if (bus_addr == A_STS)  bus_rdata = DW'({st_q.sts, {EVT_LSB{1'b0}}});
        if (bus_addr == A_EN)   bus_rdata = DW'({st_q.en,  {EVT_LSB{1'b0}}});
    end

    assign irq_o = |st_q.sts;
endmodule

// File: rtl/tmrbank_chk.sv
module tmrbank_chk
    import tmrbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NRATE-1:0]  tick_i,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              irq_o,
    input logic [NCH-1:0]    hit,
    input logic [NCH-1:0]    en,
    input logic [NCH-1:0]    sts,
    input logic [NCH-1:0]    per,
    input logic [DW-1:0]     snap
);
    // R6: an enabled event raises the interrupt next cycle
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & en) != '0) |=> irq_o);

    // R9: a clear that leaves nothing set, with no new event, drops the interrupt
    p_clear_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STS && ((hit & en) == '0)
         && ((sts & ~bus_wdata[EVT_LSB +: NCH]) == '0)) |=> !irq_o);

    // R2: an event needs a rate strobe in its cycle
    p_hit_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> (tick_i != '0));

    // R7: a one-shot channel cannot fire in two cycles in a row without a write
    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((hit & ~per) != '0) && !bus_wr) |=> ((hit & $past(hit & ~per)) == '0));

    // R10: the snapshot only changes after a read
    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(snap));
endmodule

bind tmrbank tmrbank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq_o    (irq_o),
    .hit      (hit_w),
    .en       (st_q.en),
    .sts      (st_q.sts),
    .per      (per_w),
    .snap     (st_q.snap)
);

// File: tb/tmrbank_tb.sv
module tmrbank_tb;
    localparam logic [7:0] M_MAT = 8'h80, M_CNT = 8'h40, M_CTL = 8'hC0;
    localparam logic [7:0] M_SNAP = 8'h20, M_STS = 8'h28, M_EN = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_i = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0, n_fail = 0, n_cyc = 0;
    logic [31:0] last_rd;
    logic        last_irq;

    // reference state
    logic [31:0] mcnt [8];
    logic [31:0] mmat [8];
    logic [9:0]  mctl [8];
    logic [7:0]  marm, men, msts;
    logic [31:0] msnap;

    always #4 clk = ~clk;

    tmrbank u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog R1: actual hung expected finish");
            summary();
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] a);
        if (a >= M_MAT && a <= 8'h9C) return "R7";
        if (a >= M_CNT && a <= 8'h5C) return "R2";
        if (a >= M_CTL && a <= 8'hDC) return "R3";
        if (a == M_SNAP) return "R10";
        if (a == M_STS || a == M_EN) return "R6";
        return "R1";
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        for (int n = 0; n < 8; n++) begin
            if (a == M_CNT + 8'(n * 4)) return mcnt[n];
            if (a == M_MAT + 8'(n * 4)) return mmat[n];
            if (a == M_CTL + 8'(n * 4)) return {22'b0, mctl[n]};
        end
        if (a == M_SNAP) return msnap;
        if (a == M_STS) return {20'b0, msts, 4'b0};
        if (a == M_EN)  return {20'b0, men, 4'b0};
        return 32'b0;
    endfunction

    task automatic m_reset();
        for (int n = 0; n < 8; n++) begin
            mcnt[n] = '0; mmat[n] = '0; mctl[n] = '0;
        end
        marm = '0; men = '0; msts = '0; msnap = '0;
    endtask

    task automatic m_step(input logic [3:0] tk, input logic w, input logic r,
                          input logic [7:0] a, input logic [31:0] d);
        logic [7:0] adv, hit;
        logic [31:0] ncnt [8];
        for (int k = 0; k < 8; k++) begin
            int code = int'(mctl[k][2:0]);
            logic run = (code >= 1 && code <= 4);
            if (k >= 4 && mctl[k][8]) run = 1'b0;
            if (!(k == 0 || k == 4 || k == 6) && !mctl[k][7]) run = 1'b0;
            adv[k] = run ? tk[code-1] : 1'b0;
        end
        for (int n = 0; n < 8; n++) begin
            int s = mctl[n][7] ? n : (n < 4 ? 0 : (n < 6 ? 4 : 6));
            hit[n] = marm[n] && adv[s] && (mcnt[s] + 32'd1 == mmat[n]);
        end
        if (r && a == 8'h54 && mctl[5][9]) msnap = mcnt[4];
        if (r && a == 8'h5C && mctl[7][9]) msnap = mcnt[6];
        for (int k = 0; k < 8; k++) begin
            ncnt[k] = mcnt[k];
            if (adv[k]) ncnt[k] = mcnt[k] + 32'd1;
            if (hit[k] && mctl[k][3]) ncnt[k] = '0;
            if (w && a == M_CNT + 8'(k * 4)) ncnt[k] = d;
            if (hit[k] && !mctl[k][6]) marm[k] = 1'b0;
            if (w && a == M_MAT + 8'(k * 4)) begin mmat[k] = d; marm[k] = 1'b1; end
            if (w && a == M_CTL + 8'(k * 4)) mctl[k] = (k < 4) ? {2'b0, d[7:0]} : d[9:0];
        end
        for (int k = 0; k < 8; k++) mcnt[k] = ncnt[k];
        if (w && a == M_EN) men = d[11:4];
        if (w && a == M_STS) msts = msts & ~d[11:4];
        msts = msts | (hit & men);
    endtask

    task automatic cyc(input logic [3:0] tk, input logic w, input logic r,
                       input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_i = tk; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        #1;
        last_rd = bus_rdata;
        last_irq = irq_o;
        if (r) chk(bus_rdata, m_read(a), tag_of(a));
        chk({31'b0, irq_o}, {31'b0, |msts}, "R9");
        m_step(tk, w, r, a, d);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(4'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic tk(input logic [3:0] t, input int times);
        for (int i = 0; i < times; i++) cyc(t, 1'b0, 1'b0, 8'h0, 32'h0);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cyc(4'b0, 1'b0, 1'b1, a, 32'h0);
        chk(last_rd, exp, tag);
    endtask

    task automatic irq_exp(input logic exp, input string tag);
        cyc(4'b0, 1'b0, 1'b0, 8'h0, 32'h0);
        chk({31'b0, last_irq}, {31'b0, exp}, tag);
    endtask

    initial begin
        void'($urandom(32'd20240));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int n = 0; n < 8; n++) begin
            rd_exp(M_CNT + 8'(n * 4), 32'h0, "R1");
            rd_exp(M_MAT + 8'(n * 4), 32'h0, "R1");
            rd_exp(M_CTL + 8'(n * 4), 32'h0, "R1");
        end
        rd_exp(M_SNAP, 32'h0, "R1");
        rd_exp(M_STS, 32'h0, "R1");
        rd_exp(M_EN, 32'h0, "R1");
        irq_exp(1'b0, "R1");

        // R2: rate selection and stopped codes
        wr(M_CTL, 32'h1);
        tk(4'b0001, 5);
        tk(4'b0010, 3);
        rd_exp(M_CNT, 32'd5, "R2");
        wr(M_CTL + 8'd4, 32'h85);
        tk(4'b1111, 3);
        rd_exp(M_CNT + 8'd4, 32'd0, "R2");
        wr(M_CTL + 8'd12, 32'h84);
        tk(4'b1000, 2);
        tk(4'b0111, 2);
        rd_exp(M_CNT + 8'd12, 32'd2, "R2");

        // R3: control width and external-sync stop
        wr(M_CTL + 8'd16, 32'h104);
        tk(4'b1000, 3);
        rd_exp(M_CNT + 8'd16, 32'd0, "R3");
        rd_exp(M_CTL + 8'd16, 32'h104, "R3");
        wr(M_CTL, 32'h3FF);
        rd_exp(M_CTL, 32'hFF, "R3");
        wr(M_CTL, 32'h1);

        // R5: load wins over increment
        cyc(4'b0001, 1'b1, 1'b0, M_CNT, 32'd100);
        rd_exp(M_CNT, 32'd100, "R5");

        // R4 + R6: follower compares against counter 0
        wr(M_CTL + 8'd4, 32'h01);
        wr(M_CNT + 8'd4, 32'd7);
        tk(4'b0001, 2);
        rd_exp(M_CNT + 8'd4, 32'd7, "R4");
        rd_exp(M_CNT, 32'd102, "R4");
        wr(M_EN, 32'h20);
        wr(M_MAT + 8'd4, 32'd104);
        tk(4'b0001, 1);
        rd_exp(M_STS, 32'h0, "R6");
        tk(4'b0001, 1);
        rd_exp(M_STS, 32'h20, "R6");
        irq_exp(1'b1, "R6");

        // R9: write-one-to-clear
        wr(M_STS, 32'h10);
        irq_exp(1'b1, "R9");
        wr(M_STS, 32'h20);
        irq_exp(1'b0, "R9");

        // R7: one-shot then periodic
        wr(M_CNT, 32'd103);
        tk(4'b0001, 1);
        rd_exp(M_STS, 32'h0, "R7");
        wr(M_CTL + 8'd4, 32'h41);
        wr(M_MAT + 8'd4, 32'd106);
        wr(M_CNT, 32'd105);
        tk(4'b0001, 1);
        rd_exp(M_STS, 32'h20, "R7");
        wr(M_STS, 32'h20);
        wr(M_CNT, 32'd105);
        tk(4'b0001, 1);
        rd_exp(M_STS, 32'h20, "R7");
        wr(M_STS, 32'h20);

        // R8: clear on match
        wr(M_CTL + 8'd8, 32'h89);
        wr(M_EN, 32'h40);
        wr(M_MAT + 8'd8, 32'd3);
        wr(M_CNT + 8'd8, 32'd1);
        tk(4'b0001, 2);
        rd_exp(M_CNT + 8'd8, 32'd0, "R8");
        rd_exp(M_STS, 32'h40, "R8");
        wr(M_STS, 32'h40);

        // R11: loading the match value raises nothing
        wr(M_MAT + 8'd8, 32'd3);
        wr(M_CNT + 8'd8, 32'd3);
        tk(4'b0000, 1);
        rd_exp(M_STS, 32'h0, "R11");
        rd_exp(M_CNT + 8'd8, 32'd3, "R11");

        // R10: snapshot of the neighbour counter
        wr(M_CTL + 8'd16, 32'h001);
        wr(M_CTL + 8'd20, 32'h200);
        wr(M_CNT + 8'd16, 32'd55);
        cyc(4'b0, 1'b0, 1'b1, 8'h54, 32'h0);
        rd_exp(M_SNAP, 32'd55, "R10");
        wr(M_CTL + 8'd20, 32'h000);
        wr(M_CNT + 8'd16, 32'd77);
        cyc(4'b0, 1'b0, 1'b1, 8'h54, 32'h0);
        rd_exp(M_SNAP, 32'd55, "R10");
        wr(M_CTL + 8'd24, 32'h000);
        wr(M_CNT + 8'd24, 32'd9);
        wr(M_CTL + 8'd28, 32'h200);
        cyc(4'b0, 1'b0, 1'b1, 8'h5C, 32'h0);
        rd_exp(M_SNAP, 32'd9, "R10");

        // constrained random phase, checked against the reference state
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  t;
            logic [7:0]  a;
            logic [31:0] d;
            int op  = int'($urandom % 9);
            int idx = int'($urandom % 8);
            t = 4'($urandom) & 4'($urandom);
            d = 32'($urandom % 64);
            case (op)
                0: cyc(t, 1'b1, 1'b0, M_CTL + 8'(idx * 4), $urandom & 32'h3FF);
                1: cyc(t, 1'b1, 1'b0, M_MAT + 8'(idx * 4), d);
                2: cyc(t, 1'b1, 1'b0, M_CNT + 8'(idx * 4), d);
                3: cyc(t, 1'b1, 1'b0, M_STS, $urandom);
                4: cyc(t, 1'b1, 1'b0, M_EN, $urandom);
                5: begin
                    a = ($urandom % 2 == 0) ? 8'h54 : 8'h5C;
                    cyc(t, 1'b0, 1'b1, a, 32'h0);
                end
                6: cyc(t, 1'b0, 1'b1, M_SNAP, 32'h0);
                7: begin
                    case ($urandom % 4)
                        0: a = M_CNT + 8'(idx * 4);
                        1: a = M_MAT + 8'(idx * 4);
                        2: a = M_CTL + 8'(idx * 4);
                        default: a = M_STS;
                    endcase
                    cyc(t, 1'b0, 1'b1, a, 32'h0);
                end
                default: cyc(t, 1'b0, 1'b0, 8'h0, 32'h0);
            endcase
        end
        for (int n = 0; n < 8; n++) rd_exp(M_CNT + 8'(n * 4), mcnt[n], "R2");

        summary();
        $finish;
    end
endmodule